// File: doc/BRIEF.md
# Locking Round-Robin Bus Arbiter

This block decides which of several agents drives a shared memory bus. Agents raise a request bit and wait for their bit of a one-hot grant. An agent whose grant is not locked performs exactly one transfer and signals its end with its done bit. Service order rotates, so the agent that just finished becomes the lowest priority and every requester is served within one full rotation.

An agent that needs a sequence of references with no other agent in between (for example a read followed by a conditional write in a compare-and-swap) raises its lock bit along with its request. If the lock bit of the winning agent is high in the arbitration cycle, the grant becomes locked. A locked grant stays with that agent through any number of done pulses, whatever addresses the other agents want. It is released only when the owner pulses done with its lock bit low. All other agents stall for that whole time. After any release the rotation restarts from the agent just after the one that owned the bus.

The controller has three states: IDLE (no grant, arbitration active), XFER (unlocked grant) and LOCK (locked grant). The transitions are GRANT_XFER (IDLE to XFER, a requester wins with its lock low), GRANT_LOCK (IDLE to LOCK, a requester wins with its lock high), XFER_END (XFER to IDLE on the owner's done) and UNLOCK (LOCK to IDLE on the owner's done with its lock low). Every other case stays in its state.

Top module: `lrr_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant to all zeros and the owner index to 0, and leaves agent 0 with the highest priority for the next arbitration.
- R2: In IDLE, the grant is registered on the edge after a request is seen. It goes to the first requesting agent found by searching upward from the priority pointer and wrapping from agent N-1 to agent 0.
- R3: The grant is one-hot or all zeros. While a grant is active, owner_o holds the index of the set bit. With no grant, owner_o is 0.
- R4: An unlocked grant ends on the first cycle in which done_i of the owner is high, even if the owner raised its lock bit later. The grant reads all zeros after that edge, and a new grant can appear one edge later.
- R5: When any grant ends, the priority pointer moves to the agent after the released owner, wrapping from N-1 to 0. The released agent therefore has the lowest priority next.
- R6: If lock_i of the winning agent is high in the arbitration cycle, the grant is locked. It is kept through done pulses for as long as the owner's lock bit stays high. Lock bits of agents that do not win have no effect.
- R7: A locked grant is released only in a cycle where the owner's done_i is high and its lock_i is low. Dropping the lock bit without done keeps the grant.
- R8: While a grant is active, requests and lock bits from other agents do not change the grant or the owner.
- R9: A grant is only given to an agent that requested in the arbitration cycle. With no requests, the grant stays all zeros.
- R10: The grant does not change while the owner's done_i is low. A done pulse from an agent that is not the owner has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_AGENTS | Per-agent bus request |
| lock_i | input | N_AGENTS | Per-agent lock qualifier, sampled for the winner at grant and for the owner at done |
| done_i | input | N_AGENTS | Per-agent end-of-transfer pulse |
| gnt_o | output | N_AGENTS | Registered one-hot grant, all zeros when the bus is free |
| owner_o | output | $clog2(N_AGENTS) | Index of the granted agent, 0 when there is no grant |

## Verification
Rotation is tried with sparse request patterns: two agents far apart, a pattern whose next requester sits at the top index, and one that wraps around to agent 0. Together they show the difference between a pointer that advances past the released owner and a fixed-priority or non-wrapping search. Locked sequences mix done pulses with the lock bit high, a lock dropped without done, and a lock bit raised during an unlocked grant. These patterns separate hold from release and show whose lock bit matters. Done pulses from non-owners, heavy competing requests during a grant, and a reset in the middle of a grant show that the grant reacts only to its owner and that priority returns to agent 0 after reset.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_LOCK = 2'd2
    } arb_state_e;

endpackage

// File: rtl/lrr_picker.sv
module lrr_picker #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = $clog2(N_AGENTS)
) (
    input  logic [N_AGENTS-1:0] req_i,
    input  logic [IDX_W-1:0]    ptr_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [N_AGENTS-1:0] onehot_o
);

    logic             found;
    logic [IDX_W-1:0] pick;

    // search upward from the pointer, wrapping at the top agent
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            int c;
            c = int'(ptr_i) + k;
            if (c >= N_AGENTS) c = c - N_AGENTS;
            if (!found && req_i[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
    end

    assign any_o = found;
    assign idx_o = pick;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_dec
        assign onehot_o[g] = found && (pick == IDX_W'(g));
    end

endmodule

// File: rtl/lrr_rr_ptr.sv
module lrr_rr_ptr #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = $clog2(N_AGENTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [IDX_W-1:0] ptr_o
);

    localparam logic [IDX_W-1:0] TOP = IDX_W'(N_AGENTS - 1);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance_i) begin
            ptr_q <= (last_i == TOP) ? '0 : last_i + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/lrr_arbiter.sv
module lrr_arbiter #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_AGENTS-1:0] req_i,
    input  logic [N_AGENTS-1:0] lock_i,
    input  logic [N_AGENTS-1:0] done_i,
    output logic [N_AGENTS-1:0] gnt_o,
    output logic [IDX_W-1:0]    owner_o
);
    import lrr_pkg::*;

    arb_state_e          state_q, state_d;
    logic [N_AGENTS-1:0] gnt_q, gnt_d;
    logic [IDX_W-1:0]    owner_q, owner_d;
    logic [IDX_W-1:0]    ptr;
    logic                win_any;
    logic [IDX_W-1:0]    win_idx;
    logic [N_AGENTS-1:0] win_oh;
    logic                own_done, own_lock, release_w;

    lrr_picker #(.N_AGENTS(N_AGENTS)) u_pick (
        .req_i    (req_i),
        .ptr_i    (ptr),
        .any_o    (win_any),
        .idx_o    (win_idx),
        .onehot_o (win_oh)
    );

    lrr_rr_ptr #(.N_AGENTS(N_AGENTS)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .advance_i (release_w),
        .last_i    (owner_q),
        .ptr_o     (ptr)
    );

    assign own_done = done_i[owner_q];
    assign own_lock = lock_i[owner_q];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            gnt_q   <= gnt_d;
            owner_q <= owner_d;
        end
    end

    // transitions: GRANT_XFER, GRANT_LOCK, XFER_END, UNLOCK
    always_comb begin
        state_d   = state_q;
        release_w = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_any) state_d = lock_i[win_idx] ? ST_LOCK : ST_XFER;
            end
            ST_XFER: begin
                if (own_done) begin
                    state_d   = ST_IDLE;
                    release_w = 1'b1;
                end
            end
            ST_LOCK: begin
                if (own_done && !own_lock) begin
                    state_d   = ST_IDLE;
                    release_w = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        gnt_d   = gnt_q;
        owner_d = owner_q;
        if (state_q == ST_IDLE && win_any) begin
            gnt_d   = win_oh;
            owner_d = win_idx;
        end else if (release_w) begin
            gnt_d   = '0;
            owner_d = '0;
        end
    end

    assign gnt_o   = gnt_q;
    assign owner_o = owner_q;

endmodule

// File: rtl/lrr_arbiter_chk.sv
module lrr_arbiter_chk #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = $clog2(N_AGENTS)
) (
    input logic                clk,
    input logic                rst,
    input logic [N_AGENTS-1:0] req_i,
    input logic [N_AGENTS-1:0] lock_i,
    input logic [N_AGENTS-1:0] done_i,
    input logic [N_AGENTS-1:0] gnt_o,
    input logic [IDX_W-1:0]    owner_o,
    input logic                locked_i
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (gnt_o == '0 && owner_o == '0));

    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    assert_owner_match_R3: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0) |-> gnt_o[owner_o]);

    assert_owner_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0) |-> (owner_o == '0));

    assert_xfer_end_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0 && !locked_i && done_i[owner_o]) |=> (gnt_o == '0));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (locked_i && done_i[owner_o] && lock_i[owner_o]) |=> $stable(gnt_o));

    assert_unlock_R7: assert property (@(posedge clk) disable iff (rst)
        (locked_i && done_i[owner_o] && !lock_i[owner_o]) |=> (gnt_o == '0));

    assert_to_requester_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i != '0) |=> ((gnt_o & $past(req_i)) != '0));

    assert_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0 && !done_i[owner_o]) |=> $stable(gnt_o));

endmodule

bind lrr_arbiter lrr_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .lock_i   (lock_i),
    .done_i   (done_i),
    .gnt_o    (gnt_o),
    .owner_o  (owner_o),
    .locked_i (state_q == lrr_pkg::ST_LOCK)
);

// File: tb/tb_lrr_arbiter.sv
`timescale 1ns/100ps
module tb_lrr_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0, lock = '0, done = '0;
    logic [N-1:0] gnt;
    logic [1:0]   owner;

    typedef struct {
        logic [N-1:0] gnt;
        logic [1:0]   owner;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done_run = 1'b0;

    always #2.5 clk = ~clk;

    lrr_arbiter #(.N_AGENTS(N)) dut (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .lock_i  (lock),
        .done_i  (done),
        .gnt_o   (gnt),
        .owner_o (owner)
    );

    // driver: apply one cycle of stimulus, queue the state expected after the edge
    task automatic step(input logic r, input logic [N-1:0] rq, input logic [N-1:0] lk,
                        input logic [N-1:0] dn, input logic [N-1:0] eg,
                        input logic [1:0] eo, input string tag);
        exp_t e;
        @(negedge clk);
        rst  = r;
        req  = rq;
        lock = lk;
        done = dn;
        e.gnt = eg;
        e.owner = eo;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (gnt !== e.gnt || owner !== e.owner) begin
                    errors++;
                    $display("FAIL %s: gnt=%b owner=%0d expected gnt=%b owner=%0d",
                             e.tag, gnt, owner, e.gnt, e.owner);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R1 reset");
        step(1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 0, "R1 reset holds");
        // rotation, pointer at 0
        step(0, 4'b1010, 4'b0000, 4'b0000, 4'b0010, 1, "R2 first from ptr 0");
        step(0, 4'b1011, 4'b1101, 4'b0000, 4'b0010, 1, "R8 others ignored");
        step(0, 4'b1011, 4'b0000, 4'b0010, 4'b0000, 0, "R4 done ends unlocked");
        step(0, 4'b1011, 4'b0000, 4'b0000, 4'b1000, 3, "R5 ptr after 1");
        step(0, 4'b1011, 4'b0000, 4'b1000, 4'b0000, 0, "R4 release agent 3");
        step(0, 4'b0011, 4'b0000, 4'b0000, 4'b0001, 0, "R5 wrap to 0");
        step(0, 4'b0011, 4'b0000, 4'b0001, 4'b0000, 0, "R4 release agent 0");
        step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R9 no request");
        step(0, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 1, "R2 lone requester");
        step(0, 4'b0010, 4'b0000, 4'b0100, 4'b0010, 1, "R10 foreign done");
        step(0, 4'b0010, 4'b0000, 4'b0010, 4'b0000, 0, "R4 release agent 1");
        // locked sequence, pointer at 2
        step(0, 4'b0100, 4'b0100, 4'b0000, 4'b0100, 2, "R6 locked grant");
        step(0, 4'b0111, 4'b0100, 4'b0100, 4'b0100, 2, "R6 done with lock held");
        step(0, 4'b0111, 4'b0000, 4'b0000, 4'b0100, 2, "R7 lock low without done");
        step(0, 4'b0111, 4'b0100, 4'b0100, 4'b0100, 2, "R6 second reference");
        step(0, 4'b0111, 4'b0011, 4'b0000, 4'b0100, 2, "R8 stall others");
        step(0, 4'b0111, 4'b0000, 4'b0100, 4'b0000, 0, "R7 unlock");
        step(0, 4'b0111, 4'b0000, 4'b0000, 4'b0001, 0, "R5 ptr 3 wraps to 0");
        step(0, 4'b0111, 4'b0000, 4'b0001, 4'b0000, 0, "R4 release agent 0");
        // lock raised during an unlocked grant, pointer at 1
        step(0, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 1, "R2 unlocked grant");
        step(0, 4'b0010, 4'b0010, 4'b0010, 4'b0000, 0, "R4 late lock ignored");
        // lock of non-winner, pointer at 2
        step(0, 4'b0110, 4'b0010, 4'b0000, 4'b0100, 2, "R6 winner unlocked");
        step(0, 4'b0110, 4'b0010, 4'b0100, 4'b0000, 0, "R6 loser lock ignored");
        // reset mid-grant, pointer at 3
        step(0, 4'b0001, 4'b0000, 4'b0000, 4'b0001, 0, "R2 grant before reset");
        step(1, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 0, "R1 reset mid grant");
        step(0, 4'b1100, 4'b0000, 4'b0000, 4'b0100, 2, "R1 priority back at 0");
        step(0, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 0, "R4 final release");
        @(negedge clk);
        @(negedge clk);
        done_run = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule